// File: doc/BRIEF.md
# Exclusive Reservation Monitor with Backing Memory

This block sits in front of a single-port word memory on a pipelined bus with separate address and data phases. In each address phase it captures the address, direction, transfer type, access size, an exclusive flag and an 8-bit master identifier. Every transfer carries a valid identifier. In the following data phase it returns the read data, an error flag, and an exclusive-success flag. For writes, the write data is taken in that data phase.

The block keeps one reservation slot for each exclusive-capable master identifier. An exclusive read places or moves that master's reservation onto the accessed word. An exclusive write succeeds only while the same master still holds a reservation on the same word, and a failed exclusive write leaves memory untouched. Any write that actually reaches memory breaks every reservation that points at that word, no matter which master issued it. Exclusive access is only honoured inside a parameterised address window and for identifiers below the slot count. Outside these limits exclusives always fail, and plain transfers behave as usual.

The monitor never stalls, so the ready output stays high. The bus here has no back-pressure: each transfer occupies one address cycle and one data cycle, and transfers may follow each other back to back.

Top module: `exmon_top`

## Requirements
- R1: After reset, ready is 1, error is 0 and exclusive-okay is 0, and no reservation exists: an exclusive write issued before any exclusive read fails.
- R2: An exclusive read (exclusive flag 1, write 0) inside the window by an identifier below SLOTS returns the word's data with exclusive-okay 1 in its data phase and reserves that word for that identifier. Exclusive-okay is never 1 for a non-exclusive transfer.
- R3: An exclusive write whose identifier holds a reservation on the same word succeeds. Exclusive-okay is 1, the memory is updated, and the reservation is consumed, so a repeat exclusive write fails.
- R4: An exclusive write with no reservation, or with a reservation on a different word, returns error 0 and exclusive-okay 0, and the memory word keeps its old value.
- R5: Any write that updates memory (a plain write, or a successful exclusive write) clears the reservation of every identifier reserved on that word, whichever master issues it.
- R6: An exclusive transfer outside the window (default byte addresses 0x000 to 0x1FF), or one from an identifier of SLOTS or more, gets exclusive-okay 0. Such a read still returns data, and such a write does not update memory. Plain transfers outside the window work normally.
- R7: A transfer to a byte address at or above MEM_WORDS*4 (default 0x400) gets error 1 and exclusive-okay 0 in its data phase, and does not write. Exclusive-okay is never 1 together with error.
- R8: Transfer types IDLE (2'b00) and BUSY (2'b01) change neither the reservations nor the memory, and give exclusive-okay 0. Only NONSEQ (2'b10) and SEQ (2'b11) are active.
- R9: Reservations of different identifiers are independent. Two masters holding reservations on different words can both complete their exclusive writes successfully.
- R10: Size encoding 0 writes one byte on lane addr[1:0], 1 writes a halfword on lane addr[1], and 2 writes the whole word. Lane n holds bits 8n+7:8n.
- R11: A second exclusive read by the same identifier moves its reservation. An exclusive write to the earlier word then fails, and one to the new word succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address, address phase |
| bus_trans | input | 2 | Transfer type: 0 idle, 1 busy, 2 nonseq, 3 seq |
| bus_write | input | 1 | 1 = write, address phase |
| bus_size | input | 3 | 0 byte, 1 halfword, 2 word |
| bus_excl | input | 1 | Exclusive flag, address phase |
| bus_mid | input | MID_W | Master identifier, address phase |
| bus_wdata | input | 32 | Write data, data phase |
| bus_ready | output | 1 | Transfer completes, always 1 |
| bus_err | output | 1 | Error response, data phase |
| bus_excl_ok | output | 1 | Exclusive success, data phase |
| bus_rdata | output | 32 | Read data, data phase |

## Verification
Every response belongs to the cycle right after the edge that samples the address phase. Read data, error and exclusive-okay all appear then, with no extra register stage. Write data is driven in that same data-phase cycle, and the memory and reservation changes take effect at the end of it. A back-to-back transfer therefore already sees them in its own data phase. The scoreboard tags each queued expectation with the edge count at which its data phase opens, and it compares only at the falling edge of exactly that cycle.

// File: rtl/exmon_pkg.sv
package exmon_pkg;
  localparam int EXM_DW = 32;
  localparam int EXM_LANES = EXM_DW / 8;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  // byte-lane strobes for a given offset and size
  function automatic logic [EXM_LANES-1:0] lane_strobe(input logic [1:0] off,
                                                       input logic [2:0] size);
    logic [EXM_LANES-1:0] s;
    case (size)
      3'd0:    s = 4'b0001 << off;
      3'd1:    s = off[1] ? 4'b1100 : 4'b0011;
      default: s = 4'b1111;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/exmon_resv_table.sv
module exmon_resv_table #(
  parameter int SLOTS   = 4,
  parameter int WADDR_W = 10,
  localparam int SIDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [SIDX_W-1:0]  set_idx,
  input  logic [WADDR_W-1:0] set_waddr,
  input  logic               wr_commit,
  input  logic [WADDR_W-1:0] wr_waddr,
  input  logic [SIDX_W-1:0]  query_idx,
  input  logic [WADDR_W-1:0] query_waddr,
  output logic               query_hit
);
  logic               valid_q [SLOTS];
  logic [WADDR_W-1:0] addr_q  [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic own_set;
    logic snoop_hit;
    assign own_set   = set_en && (set_idx == SIDX_W'(i));
    assign snoop_hit = wr_commit && valid_q[i] && (addr_q[i] == wr_waddr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        addr_q[i]  <= '0;
      end else if (own_set) begin
        valid_q[i] <= 1'b1;
        addr_q[i]  <= set_waddr;
      end else if (snoop_hit) begin
        valid_q[i] <= 1'b0;
      end
    end

    AST_WRITE_CLEARS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_hit && !own_set) |=> !valid_q[i]); // R5
  end

  assign query_hit = valid_q[query_idx] && (addr_q[query_idx] == query_waddr);

  AST_READ_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (valid_q[$past(set_idx)] && addr_q[$past(set_idx)] == $past(set_waddr))); // R2
endmodule

// File: rtl/exmon_mem.sv
module exmon_mem
  import exmon_pkg::*;
#(
  parameter int WORDS = 256,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [IDX_W-1:0]     widx,
  input  logic [EXM_LANES-1:0] wstrb,
  input  logic [EXM_DW-1:0]    wdata,
  input  logic [IDX_W-1:0]     ridx,
  output logic [EXM_DW-1:0]    rdata
);
  logic [EXM_DW-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < EXM_LANES; b++) begin
        if (wstrb[b]) store[widx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = store[ridx];
endmodule

// File: rtl/exmon_top.sv
module exmon_top
  import exmon_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter int              MID_W      = 8,
  parameter int              SLOTS      = 4,
  parameter int              MEM_WORDS  = 256,
  parameter logic [ADDR_W-1:0] EXCL_BASE  = 12'h000,
  parameter int              EXCL_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_trans,
  input  logic              bus_write,
  input  logic [2:0]        bus_size,
  input  logic              bus_excl,
  input  logic [MID_W-1:0]  bus_mid,
  input  logic [EXM_DW-1:0] bus_wdata,
  output logic              bus_ready,
  output logic              bus_err,
  output logic              bus_excl_ok,
  output logic [EXM_DW-1:0] bus_rdata
);
  localparam int WADDR_W = ADDR_W - 2;
  localparam int MIDX_W  = $clog2(MEM_WORDS);
  localparam int SIDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [ADDR_W:0] MEM_LIMIT = (ADDR_W+1)'(MEM_WORDS * 4);
  localparam logic [ADDR_W:0] WIN_LIMIT = (ADDR_W+1)'(EXCL_BYTES);
  localparam logic [MID_W:0]  MID_LIMIT = (MID_W+1)'(SLOTS);

  // address-phase capture
  logic              dp_act, dp_write, dp_excl;
  logic [ADDR_W-1:0] dp_addr;
  logic [2:0]        dp_size;
  logic [MID_W-1:0]  dp_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_act   <= 1'b0;
      dp_write <= 1'b0;
      dp_excl  <= 1'b0;
      dp_addr  <= '0;
      dp_size  <= '0;
      dp_mid   <= '0;
    end else begin
      dp_act   <= (bus_trans == TR_NONSEQ) || (bus_trans == TR_SEQ);
      dp_write <= bus_write;
      dp_excl  <= bus_excl;
      dp_addr  <= bus_addr;
      dp_size  <= bus_size;
      dp_mid   <= bus_mid;
    end
  end

  // data-phase decisions
  logic [ADDR_W-1:0]  win_off;
  logic               in_mem, in_win, mid_ok, excl_cap;
  logic               rd_ok, wr_ok, wr_commit, resv_hit;
  logic [WADDR_W-1:0] dp_waddr;
  logic [SIDX_W-1:0]  slot_idx;
  logic [MIDX_W-1:0]  mem_idx;
  logic [EXM_DW-1:0]  mem_rdata;

  assign win_off   = dp_addr - EXCL_BASE;
  assign in_mem    = {1'b0, dp_addr} < MEM_LIMIT;
  assign in_win    = {1'b0, win_off} < WIN_LIMIT;
  assign mid_ok    = {1'b0, dp_mid} < MID_LIMIT;
  assign dp_waddr  = dp_addr[ADDR_W-1:2];
  assign slot_idx  = dp_mid[SIDX_W-1:0];
  assign mem_idx   = dp_addr[2 +: MIDX_W];

  assign excl_cap  = dp_act && dp_excl && in_mem && in_win && mid_ok;
  assign rd_ok     = excl_cap && !dp_write;
  assign wr_ok     = excl_cap && dp_write && resv_hit;
  assign wr_commit = dp_act && dp_write && in_mem && (!dp_excl || wr_ok);

  exmon_resv_table #(.SLOTS(SLOTS), .WADDR_W(WADDR_W)) resv_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (rd_ok),
    .set_idx    (slot_idx),
    .set_waddr  (dp_waddr),
    .wr_commit  (wr_commit),
    .wr_waddr   (dp_waddr),
    .query_idx  (slot_idx),
    .query_waddr(dp_waddr),
    .query_hit  (resv_hit)
  );

  exmon_mem #(.WORDS(MEM_WORDS)) mem_i (
    .clk  (clk),
    .we   (wr_commit),
    .widx (mem_idx),
    .wstrb(lane_strobe(dp_addr[1:0], dp_size)),
    .wdata(bus_wdata),
    .ridx (mem_idx),
    .rdata(mem_rdata)
  );

  assign bus_ready   = 1'b1;
  assign bus_err     = dp_act && !in_mem;
  assign bus_excl_ok = rd_ok || wr_ok;
  assign bus_rdata   = (dp_act && !dp_write && in_mem) ? mem_rdata : '0;

  AST_OK_NOT_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_excl_ok |-> !bus_err); // R7
  AST_OK_ONLY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_excl_ok |-> (dp_act && dp_excl)); // R2
  AST_FAILED_XW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_act && dp_excl && dp_write && !bus_excl_ok) |-> !wr_commit); // R4
  AST_IDLE_NO_RESERVE: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_act |-> (!rd_ok && !wr_commit && !bus_excl_ok)); // R8
endmodule

// File: tb/exmon_top_tb_top.sv
module exmon_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [1:0]  bus_trans = 2'b00;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_size = 3'd2;
  logic        bus_excl = 1'b0;
  logic [7:0]  bus_mid = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, bus_err, bus_excl_ok;
  logic [31:0] bus_rdata;

  always #5 clk = ~clk;

  exmon_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_trans(bus_trans),
    .bus_write(bus_write), .bus_size(bus_size), .bus_excl(bus_excl),
    .bus_mid(bus_mid), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_err(bus_err), .bus_excl_ok(bus_excl_ok), .bus_rdata(bus_rdata)
  );

  typedef struct {
    int          due;
    logic        ok;
    logic        err;
    logic        chk_rd;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  int          cyc = 0;
  int          errors = 0;
  int          checks = 0;
  logic [31:0] pend_wd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void check(input logic cond, input string tag,
                                input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (expq.size() > 0 && expq[0].due == cyc) begin
      exp_t e;
      e = expq.pop_front();
      check(bus_ready == 1'b1, {e.tag, " ready"}, 32'(bus_ready), 32'd1);
      check(bus_excl_ok == e.ok, {e.tag, " excl_ok"}, 32'(bus_excl_ok), 32'(e.ok));
      check(bus_err == e.err, {e.tag, " err"}, 32'(bus_err), 32'(e.err));
      if (e.chk_rd) check(bus_rdata == e.rd, {e.tag, " rdata"}, bus_rdata, e.rd);
    end
  end

  task automatic xfer(input logic [11:0] a, input logic wr, input logic [2:0] sz,
                      input logic ex, input logic [7:0] mid, input logic [31:0] wd,
                      input logic eok, input logic eerr, input logic crd,
                      input logic [31:0] erd, input string tag);
    exp_t e;
    @(negedge clk);
    bus_wdata = pend_wd;
    bus_addr  = a;
    bus_trans = 2'b10;
    bus_write = wr;
    bus_size  = sz;
    bus_excl  = ex;
    bus_mid   = mid;
    pend_wd   = wd;
    e.due = cyc + 1; e.ok = eok; e.err = eerr; e.chk_rd = crd; e.rd = erd; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic idle(input logic [1:0] tr, input string tag);
    exp_t e;
    @(negedge clk);
    bus_wdata = pend_wd;
    bus_trans = tr;
    bus_write = 1'b1;
    bus_excl  = 1'b1;
    bus_mid   = 8'd1;
    bus_addr  = 12'h040;
    pend_wd   = 32'hDEAD_BEEF;
    e.due = cyc + 1; e.ok = 1'b0; e.err = 1'b0; e.chk_rd = 1'b0; e.rd = '0; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    xfer(a, 1'b1, 3'd2, 1'b0, 8'd3, d, 1'b0, 1'b0, 1'b0, '0, tag);
  endtask
  task automatic rd(input logic [11:0] a, input logic [31:0] d, input string tag);
    xfer(a, 1'b0, 3'd2, 1'b0, 8'd3, '0, 1'b0, 1'b0, 1'b1, d, tag);
  endtask
  task automatic xr(input logic [7:0] m, input logic [11:0] a, input logic eok,
                    input logic [31:0] d, input string tag);
    xfer(a, 1'b0, 3'd2, 1'b1, m, '0, eok, 1'b0, 1'b1, d, tag);
  endtask
  task automatic xw(input logic [7:0] m, input logic [11:0] a, input logic [31:0] d,
                    input logic eok, input string tag);
    xfer(a, 1'b1, 3'd2, 1'b1, m, d, eok, 1'b0, 1'b0, '0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=0 pending items", expq.size());
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bus_ready == 1'b1 && bus_err == 1'b0 && bus_excl_ok == 1'b0, "R1 reset outputs",
          {29'd0, bus_ready, bus_err, bus_excl_ok}, 32'h4);
    rst_n = 1'b1;

    wr(12'h040, 32'hA0A0_0001, "R1 setup");
    wr(12'h080, 32'hC0C0_0003, "R5 setup");
    xw(8'd1, 12'h040, 32'hB0B0_0002, 1'b0, "R1 no reservation after reset");
    rd(12'h040, 32'hA0A0_0001, "R4 memory kept");
    xr(8'd1, 12'h040, 1'b1, 32'hA0A0_0001, "R2 exclusive read");
    xw(8'd1, 12'h040, 32'hB0B0_0002, 1'b1, "R3 exclusive write ok");
    rd(12'h040, 32'hB0B0_0002, "R3 memory updated");
    xw(8'd1, 12'h040, 32'hD0D0_0004, 1'b0, "R3 reservation consumed");
    rd(12'h040, 32'hB0B0_0002, "R4 failed write kept data");
    xr(8'd1, 12'h040, 1'b1, 32'hB0B0_0002, "R2 reread");
    xw(8'd1, 12'h044, 32'hE0E0_0005, 1'b0, "R4 other word");

    // R5: third-party write breaks all reservations on the word
    xr(8'd1, 12'h080, 1'b1, 32'hC0C0_0003, "R5 m1 reserve");
    xr(8'd2, 12'h080, 1'b1, 32'hC0C0_0003, "R5 m2 reserve");
    wr(12'h080, 32'hF0F0_0006, "R5 plain write");
    xw(8'd1, 12'h080, 32'h1111_0007, 1'b0, "R5 m1 broken");
    xw(8'd2, 12'h080, 32'h1111_0007, 1'b0, "R5 m2 broken");
    rd(12'h080, 32'hF0F0_0006, "R5 data");

    // R9: independent masters
    xr(8'd1, 12'h040, 1'b1, 32'hB0B0_0002, "R9 m1 reserve");
    xr(8'd2, 12'h080, 1'b1, 32'hF0F0_0006, "R9 m2 reserve");
    xw(8'd2, 12'h080, 32'h2222_0008, 1'b1, "R9 m2 write");
    xw(8'd1, 12'h040, 32'h3333_0009, 1'b1, "R9 m1 write");
    rd(12'h080, 32'h2222_0008, "R9 data m2");
    rd(12'h040, 32'h3333_0009, "R9 data m1");

    // R11: reservation moves
    xr(8'd1, 12'h040, 1'b1, 32'h3333_0009, "R11 first");
    xr(8'd1, 12'h080, 1'b1, 32'h2222_0008, "R11 second");
    xw(8'd1, 12'h040, 32'h4444_000A, 1'b0, "R11 old word fails");
    xw(8'd1, 12'h080, 32'h5555_000B, 1'b1, "R11 new word ok");
    rd(12'h040, 32'h3333_0009, "R11 old data");

    // R6: outside window / unsupported id
    wr(12'h300, 32'h6666_000C, "R6 plain write outside window");
    xr(8'd1, 12'h300, 1'b0, 32'h6666_000C, "R6 excl read outside window");
    xw(8'd1, 12'h300, 32'h7777_000D, 1'b0, "R6 excl write outside window");
    rd(12'h300, 32'h6666_000C, "R6 data unchanged");
    xr(8'd9, 12'h040, 1'b0, 32'h3333_0009, "R6 id above slots read");
    xw(8'd9, 12'h040, 32'h8888_000E, 1'b0, "R6 id above slots write");
    rd(12'h040, 32'h3333_0009, "R6 data unchanged id");

    // R7: error region
    xfer(12'h400, 1'b0, 3'd2, 1'b0, 8'd3, '0, 1'b0, 1'b1, 1'b0, '0, "R7 plain read err");
    xfer(12'h400, 1'b0, 3'd2, 1'b1, 8'd1, '0, 1'b0, 1'b1, 1'b0, '0, "R7 excl read err");
    xfer(12'h404, 1'b1, 3'd2, 1'b1, 8'd1, 32'h9, 1'b0, 1'b1, 1'b0, '0, "R7 excl write err");

    // R8: idle/busy leave state alone
    xr(8'd1, 12'h040, 1'b1, 32'h3333_0009, "R8 reserve");
    idle(2'b01, "R8 busy");
    idle(2'b00, "R8 idle");
    rd(12'h040, 32'h3333_0009, "R8 memory untouched");
    xw(8'd1, 12'h040, 32'hABCD_0010, 1'b1, "R8 reservation survived");
    rd(12'h040, 32'hABCD_0010, "R8 data");

    // R10: byte lanes
    wr(12'h0C0, 32'h1122_3344, "R10 word");
    xfer(12'h0C1, 1'b1, 3'd0, 1'b0, 8'd3, 32'h0000_AA00, 1'b0, 1'b0, 1'b0, '0, "R10 byte");
    rd(12'h0C0, 32'h1122_AA44, "R10 byte lane");
    xfer(12'h0C2, 1'b1, 3'd1, 1'b0, 8'd3, 32'hBEEF_0000, 1'b0, 1'b0, 1'b0, '0, "R10 half");
    rd(12'h0C0, 32'hBEEF_AA44, "R10 half lane");

    idle(2'b00, "drain");
    idle(2'b00, "drain");
    while (expq.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule